// File: doc/BRIEF.md
# Piecewise Polynomial Square Root Mantissa Evaluator

This block produces the mantissa of a floating-point square root. It receives the fraction field of a normalized operand (the value 1.F) together with one bit saying whether the unbiased exponent is odd. It returns the fraction of the root, 1.R. For an even exponent the root is sqrt(1.F), which lies in [1, sqrt 2). For an odd exponent the root is sqrt(2 x 1.F), which lies in [sqrt 2, 2). The caller halves the exponent and handles special values outside this block.

The block uses a piecewise quadratic approximation. A coefficient table has 2^K entries. One half of the table serves even operands and the other half serves odd operands. Both halves are indexed by the same top fraction bits, so sub-intervals on the even side are half as wide as on the odd side. The coefficients are derived at elaboration by constant integer functions, with no external data.

The remaining fraction bits form a reduced argument. This argument is aligned so that one datapath serves both parities. A pipelined Horner evaluator then computes the polynomial, truncating after every multiply and every add. The constant coefficient carries a built-in half-ulp offset, so the final rounding is a plain truncation. One operand can be accepted on every clock, and the latency is fixed.

Top module: `sqrt_poly_eval`

## Requirements
- R1: With `in_odd`=0 the result approximates (sqrt(1.F) - 1) x 2^WF. With `in_odd`=1 it approximates (sqrt(2 x 1.F) - 1) x 2^WF. Even results are therefore never above floor((sqrt 2 - 1) x 2^WF) + 1, and odd results are never below that floor.
- R2: `out_frac` is faithful: it equals either floor or ceil of the exact root fraction scaled by 2^WF, with ceil limited to all-ones.
- R3: When the exact root is representable in WF fraction bits (for example 1.5625 gives 1.25, and 2.25 gives 1.5), `out_frac` equals it exactly.
- R4: `out_valid` repeats `in_valid` exactly 5 cycles later (2 x degree + 1), with no extra and no missing pulses, and the result arrives in the same cycle.
- R5: Operands may be presented on consecutive cycles. Each one yields its own result, in order.
- R6: Reset (`rst_n`=0, asynchronous) empties the pipeline. `out_valid` is 0 during reset and after release until a new operand has travelled the pipeline.
- R7: Operands on sub-interval edges (fraction bits below the index all zero, all one, or at mid-interval) are faithful, for every table index and for both parities. The table index is {in_odd, in_frac[WF-1:WF-K+1]}.
- R8: An odd-exponent operand whose fraction is all ones returns all-ones, with no wrap past 2.0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_odd | input | 1 | 1 when the operand exponent is odd |
| in_frac | input | WF | Operand fraction F of 1.F |
| out_valid | output | 1 | Result present this cycle |
| out_frac | output | WF | Root fraction R of 1.R |

## Verification
The assertions assume that `in_odd` and `in_frac` are known whenever `in_valid` is high. They also assume that the parity presented with an operand is the one the caller used when halving the exponent. The range and saturation checks compare the output against the parity and fraction that entered five cycles earlier. The stimulus drives every field on a falling edge, from fixed tables and from computed sweeps that include all table indices at their interval edges. It leaves data fields at defined values even when `in_valid` is low, so no unknown can reach the pipeline.

// File: rtl/sqp_pkg.sv
package sqp_pkg;

    // Polynomial degree of every table segment.
    localparam int DEG = 2;
    // Pipeline depth: table read plus a multiply and an add stage per Horner step.
    localparam int LAT = 2 * DEG + 1;
    // Fixed-point scale used when deriving coefficients (root scaled by 2^SCL).
    localparam int SCL = 30;

    // Integer square root (floor) of a non-negative 63-bit value.
    function automatic longint isqrt(input longint n);
        longint rem;
        longint root;
        longint bit_w;
        rem   = n;
        root  = 0;
        bit_w = 64'sd1 <<< 62;
        while (bit_w > rem) bit_w = bit_w >>> 2;
        while (bit_w != 0) begin
            if (rem >= root + bit_w) begin
                rem  = rem - (root + bit_w);
                root = (root >>> 1) + bit_w;
            end else begin
                root = root >>> 1;
            end
            bit_w = bit_w >>> 2;
        end
        return root;
    endfunction

    // Shift right for non-negative amounts, left for negative ones.
    function automatic longint shift_signed(input longint v, input int sh);
        if (sh >= 0) return v >>> sh;
        return v <<< (-sh);
    endfunction

    // Coefficient `which` (0..2) of table entry `idx`, scaled by 2^frac_bits.
    // The quadratic interpolates the root at the start, middle and end of the
    // sub-interval. Coefficient 0 carries the half-ulp rounding offset.
    function automatic longint mk_coef(input int wf, input int k, input int frac_bits,
                                       input int idx, input int which);
        int     odd_half;
        int     sub;
        int     hb;
        longint base;
        longint span;
        longint v0;
        longint v1;
        longint v2;
        longint res;
        odd_half = (idx >> (k - 1)) & 1;
        sub      = idx & ((1 << (k - 1)) - 1);
        hb       = (odd_half != 0) ? (k - 2) : (k - 1);
        span     = 64'sd1 <<< (2 * SCL - hb);
        base     = (longint'(sub) <<< (2 * SCL - hb))
                 + ((odd_half != 0) ? (64'sd2 <<< (2 * SCL)) : (64'sd1 <<< (2 * SCL)));
        v0 = isqrt(base);
        v1 = isqrt(base + (span >>> 1));
        v2 = isqrt(base + span);
        case (which)
            0:       res = (v0 >>> (SCL - frac_bits)) + (64'sd1 <<< (frac_bits - wf - 1));
            1:       res = shift_signed(4 * v1 - 3 * v0 - v2, SCL - frac_bits - hb);
            default: res = shift_signed(2 * (v0 - 2 * v1 + v2), SCL - frac_bits - 2 * hb - 1 + 1);
        endcase
        return res;
    endfunction

endpackage

// File: rtl/sqp_arg_align.sv
module sqp_arg_align #(
    parameter int WF = 16,
    parameter int K  = 6
) (
    input  logic          odd_i,
    input  logic [WF-1:0] frac_i,
    output logic [K-1:0]  addr_o,
    output logic [WF-K+1:0] y_o
);
    localparam int LW = WF - K + 1;   // fraction bits below the table index

    logic [LW-1:0] low;

    always_comb begin
        low    = frac_i[LW-1:0];
        addr_o = {odd_i, frac_i[WF-1:LW]};
        // Both parities land on one scale: y = y_o * 2^-WF.
        if (odd_i) y_o = {low, 1'b0};
        else       y_o = {1'b0, low};
    end

endmodule

// File: rtl/sqp_coef_rom.sv
module sqp_coef_rom #(
    parameter int WF    = 16,
    parameter int K     = 6,
    parameter int FB    = 20,
    parameter int CW    = 23
) (
    input  logic [K-1:0]                      addr_i,
    output logic [sqp_pkg::DEG:0][CW-1:0]     coef_o
);
    localparam int ENT = 1 << K;

    logic [sqp_pkg::DEG:0][CW-1:0] tab [ENT];

    for (genvar e = 0; e < ENT; e++) begin : g_ent
        for (genvar j = 0; j <= sqp_pkg::DEG; j++) begin : g_coef
            localparam logic [CW-1:0] CVAL = CW'(sqp_pkg::mk_coef(WF, K, FB, e, j));
            assign tab[e][j] = CVAL;
        end
    end

    always_comb begin
        coef_o = tab[addr_i];
    end

endmodule

// File: rtl/sqp_horner_step.sv
module sqp_horner_step #(
    parameter int WF = 16,
    parameter int YW = 12,
    parameter int CW = 23
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 v_i,
    input  logic [YW-1:0]                        y_i,
    input  logic signed [CW-1:0]                 acc_i,
    input  logic [sqp_pkg::DEG-1:0][CW-1:0]      pend_i,
    output logic                                 v_o,
    output logic [YW-1:0]                        y_o,
    output logic signed [CW-1:0]                 acc_o,
    output logic [sqp_pkg::DEG-1:0][CW-1:0]      pend_o
);
    localparam int PRW = YW + 1 + CW;

    typedef struct packed {
        logic                                v;
        logic [YW-1:0]                       y;
        logic signed [CW-1:0]                prod;
        logic [sqp_pkg::DEG-1:0][CW-1:0]     pend;
    } mul_t;

    typedef struct packed {
        logic                                v;
        logic [YW-1:0]                       y;
        logic signed [CW-1:0]                acc;
        logic [sqp_pkg::DEG-1:0][CW-1:0]     pend;
    } add_t;

    mul_t mul_d, mul_q;
    add_t add_d, add_q;

    logic signed [PRW-1:0] y_ext;
    logic signed [PRW-1:0] acc_ext;
    logic signed [PRW-1:0] prod_full;

    always_comb begin
        y_ext     = PRW'($signed({1'b0, y_i}));
        acc_ext   = PRW'(acc_i);
        prod_full = y_ext * acc_ext;

        // Multiply stage: product truncated (floor) back to the accumulator scale.
        mul_d.v    = v_i;
        mul_d.y    = y_i;
        mul_d.prod = CW'(prod_full >>> WF);
        mul_d.pend = pend_i;

        // Add stage: next pending coefficient joins, list moves down by one.
        add_d.v    = mul_q.v;
        add_d.y    = mul_q.y;
        add_d.acc  = $signed(mul_q.pend[0]) + mul_q.prod;
        add_d.pend = mul_q.pend >> CW;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mul_q <= '0;
            add_q <= '0;
        end else begin
            mul_q <= mul_d;
            add_q <= add_d;
        end
    end

    assign v_o    = add_q.v;
    assign y_o    = add_q.y;
    assign acc_o  = add_q.acc;
    assign pend_o = add_q.pend;

endmodule

// File: rtl/sqrt_poly_eval.sv
module sqrt_poly_eval #(
    parameter int WF    = 16,
    parameter int K     = 6,
    parameter int GUARD = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_odd,
    input  logic [WF-1:0] in_frac,
    output logic          out_valid,
    output logic [WF-1:0] out_frac
);
    import sqp_pkg::*;

    localparam int FB = WF + GUARD;     // fraction bits of coefficients and sums
    localparam int CW = FB + 3;         // sign, two integer bits, fraction
    localparam int YW = WF - K + 2;     // reduced argument width
    localparam logic signed [CW-1:0] ONE_V = CW'(64'sd1 <<< FB);
    localparam logic signed [CW-1:0] TWO_V = CW'(64'sd1 <<< (FB + 1));

    typedef struct packed {
        logic                        v;
        logic [YW-1:0]               y;
        logic signed [CW-1:0]        acc;
        logic [DEG-1:0][CW-1:0]      pend;
    } rd_t;

    rd_t rd_d, rd_q;

    logic [K-1:0]           addr;
    logic [YW-1:0]          y_arg;
    logic [DEG:0][CW-1:0]   coef;

    sqp_arg_align #(.WF(WF), .K(K)) u_align (
        .odd_i  (in_odd),
        .frac_i (in_frac),
        .addr_o (addr),
        .y_o    (y_arg)
    );

    sqp_coef_rom #(.WF(WF), .K(K), .FB(FB), .CW(CW)) u_rom (
        .addr_i (addr),
        .coef_o (coef)
    );

    // Table read stage: highest coefficient starts the accumulator, the
    // others queue in the order Horner consumes them.
    always_comb begin
        rd_d.v   = in_valid;
        rd_d.y   = y_arg;
        rd_d.acc = $signed(coef[DEG]);
        for (int j = 0; j < DEG; j++) begin
            rd_d.pend[j] = coef[DEG-1-j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    logic                      v_bus    [DEG+1];
    logic [YW-1:0]             y_bus    [DEG+1];
    logic signed [CW-1:0]      acc_bus  [DEG+1];
    logic [DEG-1:0][CW-1:0]    pend_bus [DEG+1];

    assign v_bus[0]    = rd_q.v;
    assign y_bus[0]    = rd_q.y;
    assign acc_bus[0]  = rd_q.acc;
    assign pend_bus[0] = rd_q.pend;

    for (genvar s = 0; s < DEG; s++) begin : g_step
        sqp_horner_step #(.WF(WF), .YW(YW), .CW(CW)) u_step (
            .clk    (clk),
            .rst_n  (rst_n),
            .v_i    (v_bus[s]),
            .y_i    (y_bus[s]),
            .acc_i  (acc_bus[s]),
            .pend_i (pend_bus[s]),
            .v_o    (v_bus[s+1]),
            .y_o    (y_bus[s+1]),
            .acc_o  (acc_bus[s+1]),
            .pend_o (pend_bus[s+1])
        );
    end

    // Final rounding is truncation; the value is kept inside [1, 2).
    logic signed [CW-1:0] fin;
    always_comb begin
        fin = acc_bus[DEG];
        if (fin >= TWO_V)      out_frac = '1;
        else if (fin < ONE_V)  out_frac = '0;
        else                   out_frac = fin[FB-1:GUARD];
        out_valid = v_bus[DEG];
    end

endmodule

// File: rtl/sqrt_poly_eval_chk.sv
module sqrt_poly_eval_chk #(
    parameter int WF = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_odd,
    input logic [WF-1:0] in_frac,
    input logic          out_valid,
    input logic [WF-1:0] out_frac
);
    localparam int L = sqp_pkg::LAT;
    localparam logic [WF-1:0] RT2 =
        WF'(sqp_pkg::isqrt(64'sd2 <<< (2 * WF)) - (64'sd1 <<< WF));

    logic [L-1:0] sh_v;
    logic [L-1:0] sh_odd;
    logic [L-1:0] sh_top;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_v   <= '0;
            sh_odd <= '0;
            sh_top <= '0;
        end else begin
            sh_v   <= {sh_v[L-2:0], in_valid};
            sh_odd <= {sh_odd[L-2:0], in_odd};
            sh_top <= {sh_top[L-2:0], in_odd & (&in_frac)};
        end
    end

    // R4
    latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == sh_v[L-1]);

    // R6
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    // R1
    even_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !sh_odd[L-1]) |-> (out_frac <= RT2 + WF'(1)));

    // R1
    odd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sh_odd[L-1]) |-> (out_frac >= RT2));

    // R8
    top_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sh_top[L-1]) |-> (&out_frac));

    // R2
    known_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_frac));

endmodule

bind sqrt_poly_eval sqrt_poly_eval_chk #(.WF(WF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_odd    (in_odd),
    .in_frac   (in_frac),
    .out_valid (out_valid),
    .out_frac  (out_frac)
);

// File: tb/sqrt_poly_eval_tb.sv
module sqrt_poly_eval_tb;

    localparam int WF  = 16;
    localparam int LAT = 5;
    localparam int NV  = 10;
    localparam int QD  = 8192;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_odd = 1'b0;
    logic [WF-1:0] in_frac = '0;
    logic          out_valid;
    logic [WF-1:0] out_frac;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sqrt_poly_eval u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_odd(in_odd),
        .in_frac(in_frac), .out_valid(out_valid), .out_frac(out_frac)
    );

    // {odd, frac, floor of exact root fraction, root exact}
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 16'h0000, 16'd0,     1'b1},
        {1'b1, 16'h0000, 16'd27145, 1'b0},
        {1'b0, 16'h9000, 16'd16384, 1'b1},
        {1'b1, 16'h2000, 16'd32768, 1'b1},
        {1'b0, 16'hFFFF, 16'd27145, 1'b0},
        {1'b1, 16'hFFFF, 16'd65535, 1'b0},
        {1'b1, 16'h8000, 16'd47975, 1'b0},
        {1'b0, 16'h4000, 16'd7735,  1'b0},
        {1'b0, 16'h2100, 16'd4096,  1'b1},
        {1'b1, 16'h8800, 16'd49152, 1'b1}
    };

    function automatic longint tb_isqrt(input longint n);
        longint r = 0;
        for (int b = 31; b >= 0; b--) begin
            longint t = r | (64'sd1 <<< b);
            if (t * t <= n) r = t;
        end
        return r;
    endfunction

    // Allowed result pair computed from the exact root.
    task automatic expect_pair(input logic odd, input logic [WF-1:0] f,
                               output int lo, output int hi);
        longint n;
        longint r;
        n  = odd ? ((64'sd2 <<< WF) + 2 * longint'(f)) <<< WF
                 : ((64'sd1 <<< WF) + longint'(f)) <<< WF;
        r  = tb_isqrt(n);
        lo = int'(r - (64'sd1 <<< WF));
        hi = (r * r == n) ? lo : lo + 1;
        if (hi > 65535) hi = 65535;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Streaming scoreboard
    int exp_lo [QD];
    int exp_hi [QD];
    int wr_idx = 0;
    int rd_idx = 0;
    bit mon_en = 0;

    always @(negedge clk) begin
        if (mon_en && out_valid) begin
            checks++;
            if (!(int'(out_frac) == exp_lo[rd_idx] || int'(out_frac) == exp_hi[rd_idx])) begin
                failures++;
                $display("FAIL R2/R5/R7 stream item %0d actual=%0d expected=%0d or %0d",
                         rd_idx, out_frac, exp_lo[rd_idx], exp_hi[rd_idx]);
            end
            rd_idx++;
        end
    end

    task automatic push(input logic odd, input logic [WF-1:0] f, input logic v);
        int lo;
        int hi;
        @(negedge clk);
        in_valid = v;
        in_odd   = odd;
        in_frac  = f;
        if (v) begin
            expect_pair(odd, f, lo, hi);
            exp_lo[wr_idx] = lo;
            exp_hi[wr_idx] = hi;
            wr_idx++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        int lo;
        int hi;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R6 in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R6 after release", int'(out_valid), 0);

        // Table walk: single operands, latency and value (R1 R3 R4 R8)
        for (int i = 0; i < NV; i++) begin
            logic          v_odd;
            logic [WF-1:0] v_frac;
            int            v_lo;
            bit            v_ex;
            bit            early;
            v_odd  = VEC[i][33];
            v_frac = VEC[i][32:17];
            v_lo   = int'(VEC[i][16:1]);
            v_ex   = VEC[i][0];
            expect_pair(v_odd, v_frac, lo, hi);
            check(lo == v_lo, "R1 table floor", lo, v_lo);
            @(negedge clk);
            in_valid = 1'b1; in_odd = v_odd; in_frac = v_frac;
            @(negedge clk);
            in_valid = 1'b0;
            early = 0;
            for (int c = 1; c < LAT; c++) begin
                if (c > 1) @(negedge clk);
                if (out_valid) early = 1;
            end
            check(!early, "R4 no early valid", int'(early), 0);
            @(negedge clk);
            check(out_valid == 1'b1, "R4 valid at 5", int'(out_valid), 1);
            if (v_ex)
                check(int'(out_frac) == v_lo, "R3 exact root", int'(out_frac), v_lo);
            else
                check(int'(out_frac) == v_lo || int'(out_frac) == hi,
                      v_odd ? "R1 odd root" : "R1 even root", int'(out_frac), v_lo);
            if (v_odd && v_frac == 16'hFFFF)
                check(out_frac == 16'hFFFF, "R8 saturate", int'(out_frac), 65535);
            @(negedge clk);
            check(out_valid == 1'b0, "R4 single pulse", int'(out_valid), 0);
        end

        // Back-to-back stream: interval edges for every index (R7, R5)
        mon_en = 1;
        for (int p = 0; p < 2; p++)
            for (int idx = 0; idx < 32; idx++) begin
                push(p[0], 16'((idx << 11) | 0),     1'b1);
                push(p[0], 16'((idx << 11) | 2047),  1'b1);
                push(p[0], 16'((idx << 11) | 1024),  1'b1);
            end
        // Sweep of both parities, with gaps in in_valid (R2, R4)
        for (int p = 0; p < 2; p++)
            for (int m = 0; m < 2048; m++)
                push(p[0], 16'(m * 32 + (m % 32)), (m % 7) != 3);
        push(1'b0, '0, 1'b0);
        repeat (LAT + 3) @(negedge clk);
        check(rd_idx == wr_idx, "R4 R5 result count", rd_idx, wr_idx);
        mon_en = 0;

        // Reset while busy (R6)
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_odd = 1'b1; in_frac = 16'(i * 1000);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R6 reset mid-run", int'(out_valid), 0);
        rst_n = 1'b1;
        begin
            bit seen = 0;
            for (int c = 0; c < LAT + 2; c++) begin
                @(negedge clk);
                if (out_valid) seen = 1;
            end
            check(!seen, "R6 pipeline flushed", int'(seen), 0);
        end

        // First operand after reset still correct (R6, R3)
        @(negedge clk);
        in_valid = 1'b1; in_odd = 1'b0; in_frac = 16'h9000;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        check(out_valid == 1'b1 && out_frac == 16'd16384, "R6 R3 after reset",
              int'(out_frac), 16384);

        finish_run();
    end

endmodule